// File: doc/BRIEF.md
# Two-Channel Frame Signaling Capture

This block collects a low-rate signaling stream that carries two bits in each 125 µs frame. It serves two such streams side by side, and they share one bit clock and one frame sync. The fast system clock samples the bit clock, the frame sync and both data lines through synchronizer chains. The block then detects edges on the synchronized strobes.

Each falling edge of the bit clock shifts the current data bit into a small per-channel shift buffer. When the frame sync rises, the buffer of every channel is copied into a holding register. The holding register feeds the downstream modulator, and a single-cycle load strobe marks each copy. Extra bit-clock edges within a frame keep shifting, so the newest bits win. The buffer is never cleared at a frame boundary, so a short frame carries forward the bits captured before it.

Top module: `sigpair_capture`

## Requirements
- R1: Both channels are captured in parallel from the shared bit clock and frame sync. Channel c appears on word_out[2c+1:2c].
- R2: A channel's data bit is sampled only on a falling edge of bclk_in. The level of ser_in at a rising edge has no effect.
- R3: After two falling edges in a frame, bit 1 of the channel word holds the first captured bit and bit 0 holds the second.
- R4: When more than two falling edges occur in a frame, each one shifts in a new bit and drops the oldest, so the word holds the last two bits in capture order.
- R5: word_out changes only on a rising edge of fsync_in. Bit-clock edges alone leave it unchanged.
- R6: Every rising edge of fsync_in gives exactly one load_stb pulse, one clock cycle long, in the same cycle that word_out takes the new value.
- R7: The buffer is not cleared at a transfer. A frame with fewer than two falling edges transfers the older bits still in the buffer, and a frame with none repeats the previous word.
- R8: While rst is high, the shift buffers, word_out and load_stb are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Shared signaling bit clock, asynchronous to clk |
| fsync_in | input | 1 | Shared 8 kHz frame sync, asynchronous to clk |
| ser_in | input | NUM_CH | Serial data, one line per channel |
| word_out | output | NUM_CH*BITS | Held words, channel c in bits [2c+1:2c] |
| load_stb | output | 1 | One-cycle pulse when word_out is reloaded |

## Verification
The assertions assume that bclk_in and fsync_in hold each level for longer than the synchronizer depth plus one clock. They also assume that ser_in is stable over the synchronizer window around a falling bit-clock edge. Finally, they assume that a frame-sync rise never shares a sampled cycle with a bit-clock fall. The stimulus keeps every strobe level for at least four clocks. It changes data two clocks before a falling edge, and it holds the frame sync until all bit-clock activity has settled. To expose sampling on the wrong edge, the stimulus inverts the data between each fall and the following rise.

// File: rtl/sigcap_pkg.sv
package sigcap_pkg;
  localparam int DEF_CH   = 2;
  localparam int DEF_BITS = 2;
  localparam int DEF_SYNC = 2;
endpackage

// File: rtl/sigcap_sync.sv
module sigcap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/sigcap_edge.sv
module sigcap_edge #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic evt
);
  logic lvl;
  logic prev_q;

  sigcap_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in (raw_in),
    .d_out(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = prev_q & ~lvl;
    end else begin : g_rise
      assign evt = lvl & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/sigcap_lane.sv
module sigcap_lane #(
  parameter int BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_evt,
  input  logic            load_evt,
  input  logic            din,
  output logic [BITS-1:0] buf_q,
  output logic [BITS-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else if (shift_evt) begin
      buf_q <= {buf_q[BITS-2:0], din};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load_evt) begin
      hold_q <= buf_q;
    end
  end
endmodule

// File: rtl/sigpair_capture.sv
module sigpair_capture
  import sigcap_pkg::*;
#(
  parameter int NUM_CH = DEF_CH,
  parameter int BITS   = DEF_BITS,
  parameter int SYNC   = DEF_SYNC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bclk_in,
  input  logic                   fsync_in,
  input  logic [NUM_CH-1:0]      ser_in,
  output logic [NUM_CH*BITS-1:0] word_out,
  output logic                   load_stb
);
  localparam int WW = NUM_CH * BITS;

  logic              bclk_fall;
  logic              fs_rise;
  logic [NUM_CH-1:0] ser_sync;
  logic [WW-1:0]     cap_buf;

  sigcap_edge #(.STAGES(SYNC), .FALLING(1'b1)) u_bclk_edge (
    .clk   (clk),
    .rst   (rst),
    .raw_in(bclk_in),
    .evt   (bclk_fall)
  );

  sigcap_edge #(.STAGES(SYNC), .FALLING(1'b0)) u_fsync_edge (
    .clk   (clk),
    .rst   (rst),
    .raw_in(fsync_in),
    .evt   (fs_rise)
  );

  // Data shares the strobe sync depth so a sample lines up with its edge.
  sigcap_sync #(.WIDTH(NUM_CH), .STAGES(SYNC)) u_data_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in (ser_in),
    .d_out(ser_sync)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      sigcap_lane #(.BITS(BITS)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .shift_evt(bclk_fall),
        .load_evt (fs_rise),
        .din      (ser_sync[c]),
        .buf_q    (cap_buf[c*BITS +: BITS]),
        .hold_q   (word_out[c*BITS +: BITS])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) load_stb <= 1'b0;
    else     load_stb <= fs_rise;
  end
endmodule

// File: rtl/sigpair_capture_chk.sv
module sigpair_capture_chk #(
  parameter int NUM_CH = 2,
  parameter int BITS   = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   load_stb,
  input logic                   bclk_fall,
  input logic [NUM_CH*BITS-1:0] word_out,
  input logic [NUM_CH*BITS-1:0] cap_buf
);
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

  p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load_stb |-> $stable(word_out));

  p_load_copy_r7: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (word_out == $past(cap_buf)));

  p_buf_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !bclk_fall |=> $stable(cap_buf));

  p_reset_zero_r8: assert property (@(posedge clk)
    rst |=> (word_out == '0 && !load_stb && cap_buf == '0));
endmodule

bind sigpair_capture sigpair_capture_chk #(.NUM_CH(NUM_CH), .BITS(BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_stb (load_stb),
  .bclk_fall(bclk_fall),
  .word_out (word_out),
  .cap_buf  (cap_buf)
);

// File: tb/sigpair_capture_tb.sv
module sigpair_capture_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk_in = 1'b1;
  logic       fsync_in = 1'b0;
  logic [1:0] ser_in = 2'b00;
  logic [3:0] word_out;
  logic       load_stb;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 1'b0;
  logic [1:0] mbuf0 = 2'b00;
  logic [1:0] mbuf1 = 2'b00;
  logic [3:0] last_word = 4'h0;

  always #10 clk = ~clk;

  sigpair_capture u_dut (
    .clk     (clk),
    .rst     (rst),
    .bclk_in (bclk_in),
    .fsync_in(fsync_in),
    .ser_in  (ser_in),
    .word_out(word_out),
    .load_stb(load_stb)
  );

  always @(posedge clk) if (load_stb) stb_cnt++;

  // Vector: {edges[2:0], ch0 bits[3:0], ch1 bits[3:0]}; bit i goes out on edge i.
  localparam logic [10:0] VEC [12] = '{
    {3'd2, 4'b0010, 4'b0001},
    {3'd2, 4'b0011, 4'b0000},
    {3'd0, 4'b0000, 4'b0000},
    {3'd1, 4'b0001, 4'b0000},
    {3'd3, 4'b0101, 4'b0110},
    {3'd4, 4'b1001, 4'b0110},
    {3'd2, 4'b0000, 4'b0011},
    {3'd1, 4'b0000, 4'b0001},
    {3'd0, 4'b0000, 4'b0000},
    {3'd4, 4'b1111, 4'b0000},
    {3'd2, 4'b0001, 4'b0010},
    {3'd3, 4'b0110, 4'b0011}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic [3:0] b0, input logic [3:0] b1);
    logic [3:0] exp_word;
    stb_cnt = 0;
    for (int i = 0; i < n; i++) begin
      ser_in = {b1[i], b0[i]};
      wait_cyc(2);
      bclk_in = 1'b0;
      mbuf0 = {mbuf0[0], b0[i]};
      mbuf1 = {mbuf1[0], b1[i]};
      wait_cyc(4);
      ser_in = ~{b1[i], b0[i]};   // inverted level at the rising edge (R2)
      wait_cyc(2);
      bclk_in = 1'b1;
      wait_cyc(4);
    end
    wait_cyc(4);
    check(word_out == last_word, "R5 word before sync", word_out, last_word);
    check(stb_cnt == 0, "R6 no strobe before sync", stb_cnt, 0);
    fsync_in = 1'b1;
    wait_cyc(6);
    exp_word = {mbuf1, mbuf0};
    check(word_out == exp_word, "R1 R2 R3 R4 R7 word after sync", word_out, exp_word);
    check(stb_cnt == 1, "R6 one strobe per sync", stb_cnt, 1);
    last_word = exp_word;
    fsync_in = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(3);
    check(word_out == 4'h0, "R8 reset word", word_out, 0);
    check(load_stb == 1'b0, "R8 reset strobe", load_stb, 0);
    rst = 1'b0;
    wait_cyc(4);
    for (int v = 0; v < 12; v++) begin
      run_frame(int'(VEC[v][10:8]), VEC[v][7:4], VEC[v][3:0]);
    end
    // Strobe width: sample the cycle of the pulse and the cycle after it (R6).
    stb_cnt = 0;
    fsync_in = 1'b1;
    @(posedge load_stb);
    @(negedge clk);
    check(load_stb == 1'b1, "R6 strobe high", load_stb, 1);
    @(negedge clk);
    check(load_stb == 1'b0, "R6 strobe one cycle", load_stb, 0);
    fsync_in = 1'b0;
    wait_cyc(4);
    // Reset in mid-frame with the buffer full clears everything (R8).
    run_frame(2, 4'b0011, 4'b0011);
    ser_in = 2'b11;
    wait_cyc(2);
    bclk_in = 1'b0;
    wait_cyc(4);
    rst = 1'b1;
    bclk_in = 1'b1;
    wait_cyc(3);
    check(word_out == 4'h0, "R8 mid-run reset word", word_out, 0);
    rst = 1'b0;
    mbuf0 = 2'b00;
    mbuf1 = 2'b00;
    last_word = 4'h0;
    wait_cyc(4);
    run_frame(0, 4'b0000, 4'b0000);   // cleared buffer carries zeros (R8)
    run_frame(1, 4'b0001, 4'b0001);   // single edge after clear (R7)
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule